// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds a small set of general-purpose registers, each one word wide, where every word can also be reached as two separate byte registers. A byte register and the word that contains it share the same storage, so software may build a word a byte at a time, or pick one byte out of a word, without any extra copy step. Two read ports and one write port serve the datapath. Each port takes a register index and a size select.

Besides plain reads and writes, the block can swap two registers of the same size on its own. A swap runs through a private holding register that no index can reach. This means neither value is lost, even when the two operands are the two halves of one word. The swap runs as a fixed three-step sequence and shows a busy flag while it runs. A register-to-register move needs no special support: the datapath reads the source on a read port and writes the value back on the write port.

Top module: `gpr_bytefile`

## Requirements
- R1: After a synchronous reset, both read data outputs are zero and the busy flag is low.
- R2: A word access (size select 1) names a register by index bits [1:0]. Index bit 2 is ignored. A word read returns all 16 bits.
- R3: A byte access (size select 0) uses index bit 2 to pick the half: 0 is bits 7:0 and 1 is bits 15:8. Bits [1:0] pick the register. With word 0x1234, index 0 reads 0x0034 and index 4 reads 0x0012. A byte read drives the upper 8 output bits as zero.
- R4: A byte write changes only its own half. The other 8 bits of that register keep their value.
- R5: Writing the high byte and then the low byte of a register leaves the same word as a single word write of the combined value.
- R6: Read data is registered and appears one cycle after the index. A read of a register that is written in the same cycle returns the value from before the write.
- R7: The two read ports work independently. Given the same index and size in the same cycle, they return the same data.
- R8: When the swap start is sampled while the block is idle, busy is high for exactly the next three cycles. After that, the two registers hold each other's former values.
- R9: A byte swap exchanges only the two named halves, including the two halves of one register. All other bytes keep their value.
- R10: While busy is high, the write port and the swap start have no effect.
- R11: A move, done as a read of the source followed by a write of that value to the destination, copies the value and leaves the source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write index |
| wr_size | input | 1 | Write size, 1 = word, 0 = byte |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| rd_a_idx | input | 3 | Read port A index |
| rd_a_size | input | 1 | Read port A size |
| rd_a_data | output | 16 | Read port A data, registered |
| rd_b_idx | input | 3 | Read port B index |
| rd_b_size | input | 1 | Read port B size |
| rd_b_data | output | 16 | Read port B data, registered |
| xchg_start | input | 1 | Start a swap |
| xchg_idx_x | input | 3 | First swap operand index |
| xchg_idx_y | input | 3 | Second swap operand index |
| xchg_size | input | 1 | Swap size |
| xchg_busy | output | 1 | Swap in progress |

## Verification
The bench builds the block with its default parameters: four registers with 8-bit halves. At this size every one of the eight byte indices and every word index can be reached in a short directed run. This covers each half-select case, swaps across registers and within one register, and the word-index bit that must be ignored. The timing cases are checked on exact cycles: the read-during-write old value and the three-cycle busy window with writes and restarts blocked inside it.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam logic SZ_BYTE = 1'b0;
  localparam logic SZ_WORD = 1'b1;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_SAVE = 2'd1,
    XS_MOVE = 2'd2,
    XS_REST = 2'd3
  } xchg_state_t;
endpackage

// File: rtl/gpr_byte_bank.sv
module gpr_byte_bank #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [W-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/gpr_xchg_seq.sv
module gpr_xchg_seq
  import gpr_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  idx_x,
  input  logic [IDX_W-1:0]  idx_y,
  input  logic              size,
  input  logic [WORD_W-1:0] peek_data,
  output logic [IDX_W-1:0]  peek_idx,
  output logic              op_size,
  output logic              busy,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  xchg_state_t       state;
  logic [IDX_W-1:0]  x_q, y_q;
  logic              size_q;
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= XS_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      size_q <= SZ_WORD;
      hold_q <= '0;
    end else begin
      unique case (state)
        XS_IDLE: if (start) begin
          x_q    <= idx_x;
          y_q    <= idx_y;
          size_q <= size;
          state  <= XS_SAVE;
        end
        XS_SAVE: begin
          hold_q <= peek_data;
          state  <= XS_MOVE;
        end
        XS_MOVE: state <= XS_REST;
        XS_REST: state <= XS_IDLE;
        default: state <= XS_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state != XS_IDLE);
    op_size  = size_q;
    peek_idx = (state == XS_SAVE) ? x_q : y_q;
    wr_en    = 1'b0;
    wr_idx   = x_q;
    wr_data  = peek_data;
    if (state == XS_MOVE) begin
      wr_en = 1'b1;
    end else if (state == XS_REST) begin
      wr_en   = 1'b1;
      wr_idx  = y_q;
      wr_data = hold_q;
    end
  end
endmodule

// File: rtl/gpr_bytefile.sv
module gpr_bytefile
  import gpr_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = 2 * BYTE_W,
  localparam int RIDX_W  = $clog2(NUM_REGS),
  localparam int IDX_W   = RIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_size,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic              rd_a_size,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              rd_b_size,
  output logic [WORD_W-1:0] rd_b_data,
  input  logic              xchg_start,
  input  logic [IDX_W-1:0]  xchg_idx_x,
  input  logic [IDX_W-1:0]  xchg_idx_y,
  input  logic              xchg_size,
  output logic              xchg_busy
);
  localparam int NRD = 3;  // port A, port B, swap peek

  logic [NRD-1:0][IDX_W-1:0]  ridx;
  logic [NRD-1:0]             rsz;
  logic [NRD-1:0][RIDX_W-1:0] raddr;
  logic [1:0][NRD-1:0][BYTE_W-1:0] bank_rd;
  logic [NRD-1:0][WORD_W-1:0] comp;

  logic              seq_busy, seq_wr_en, seq_size;
  logic [IDX_W-1:0]  seq_wr_idx, seq_peek_idx;
  logic [WORD_W-1:0] seq_wr_data;

  logic              w_en, w_size;
  logic [IDX_W-1:0]  w_idx;
  logic [WORD_W-1:0] w_data;
  logic [1:0]              bank_we;
  logic [1:0][BYTE_W-1:0]  bank_wd;

  assign ridx[0] = rd_a_idx;
  assign ridx[1] = rd_b_idx;
  assign ridx[2] = seq_peek_idx;
  assign rsz[0]  = rd_a_size;
  assign rsz[1]  = rd_b_size;
  assign rsz[2]  = seq_size;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign raddr[p] = ridx[p][RIDX_W-1:0];
    always_comb begin
      if (rsz[p] == SZ_WORD)
        comp[p] = {bank_rd[1][p], bank_rd[0][p]};
      else
        comp[p] = {{BYTE_W{1'b0}},
                   ridx[p][IDX_W-1] ? bank_rd[1][p] : bank_rd[0][p]};
    end
  end

  // Swap sequence has the write path while it runs; the port is shut out.
  always_comb begin
    if (seq_wr_en) begin
      w_en = 1'b1;  w_idx = seq_wr_idx; w_size = seq_size; w_data = seq_wr_data;
    end else begin
      w_en = wr_en && !seq_busy; w_idx = wr_idx; w_size = wr_size; w_data = wr_data;
    end
  end

  assign bank_we[0] = w_en && (w_size == SZ_WORD || !w_idx[IDX_W-1]);
  assign bank_we[1] = w_en && (w_size == SZ_WORD ||  w_idx[IDX_W-1]);
  assign bank_wd[0] = w_data[BYTE_W-1:0];
  assign bank_wd[1] = (w_size == SZ_WORD) ? w_data[WORD_W-1:BYTE_W]
                                          : w_data[BYTE_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    gpr_byte_bank #(.DEPTH(NUM_REGS), .W(BYTE_W), .NRD(NRD)) bank_i (
      .clk   (clk),
      .we    (bank_we[h]),
      .waddr (w_idx[RIDX_W-1:0]),
      .wdata (bank_wd[h]),
      .raddr (raddr),
      .rdata (bank_rd[h])
    );
  end

  gpr_xchg_seq #(.IDX_W(IDX_W), .WORD_W(WORD_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (xchg_start),
    .idx_x     (xchg_idx_x),
    .idx_y     (xchg_idx_y),
    .size      (xchg_size),
    .peek_data (comp[2]),
    .peek_idx  (seq_peek_idx),
    .op_size   (seq_size),
    .busy      (seq_busy),
    .wr_en     (seq_wr_en),
    .wr_idx    (seq_wr_idx),
    .wr_data   (seq_wr_data)
  );

  assign xchg_busy = seq_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
    end else begin
      rd_a_data <= comp[0];
      rd_b_data <= comp[1];
    end
  end
endmodule

// File: rtl/gpr_bytefile_chk.sv
module gpr_bytefile_chk
  import gpr_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic              rd_a_size,
  input logic [WORD_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic              rd_b_size,
  input logic [WORD_W-1:0] rd_b_data,
  input logic              xchg_start,
  input logic              xchg_busy
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!xchg_busy && rd_a_data == '0 && rd_b_data == '0));

  assert_byte_zext_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_a_size == SZ_BYTE) |=> (rd_a_data[WORD_W-1:BYTE_W] == '0));

  assert_ports_agree_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx && rd_a_size == rd_b_size) |=> (rd_a_data == rd_b_data));

  assert_busy_window_R8: assert property (@(posedge clk) disable iff (rst)
    (xchg_start && !xchg_busy) |=> xchg_busy ##1 xchg_busy ##1 xchg_busy ##1 !xchg_busy);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(xchg_busy) |-> $past(xchg_busy, 3));
endmodule

bind gpr_bytefile gpr_bytefile_chk #(.IDX_W(IDX_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rd_a_idx   (rd_a_idx),
  .rd_a_size  (rd_a_size),
  .rd_a_data  (rd_a_data),
  .rd_b_idx   (rd_b_idx),
  .rd_b_size  (rd_b_size),
  .rd_b_data  (rd_b_data),
  .xchg_start (xchg_start),
  .xchg_busy  (xchg_busy)
);

// File: tb/gpr_bytefile_tb_top.sv
`timescale 1ns/1ps
module gpr_bytefile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic        wr_size = 1'b1;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_a_idx = '0;
  logic        rd_a_size = 1'b1;
  logic [15:0] rd_a_data;
  logic [2:0]  rd_b_idx = '0;
  logic        rd_b_size = 1'b1;
  logic [15:0] rd_b_data;
  logic        xchg_start = 1'b0;
  logic [2:0]  xchg_idx_x = '0;
  logic [2:0]  xchg_idx_y = '0;
  logic        xchg_size = 1'b1;
  logic        xchg_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpr_bytefile dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic sz, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, input logic sz, output logic [15:0] d);
    rd_a_idx = idx; rd_a_size = sz;
    @(posedge clk); @(negedge clk);
    d = rd_a_data;
  endtask

  task automatic t_reset;
    chk("R1 rd_a after reset", rd_a_data, 16'h0);
    chk("R1 rd_b after reset", rd_b_data, 16'h0);
    chk("R1 busy after reset", {15'b0, xchg_busy}, 16'h0);
  endtask

  task automatic t_word;
    logic [15:0] d;
    wr(3'd0, 1'b1, 16'h1234);
    wr(3'd1, 1'b1, 16'hAAAA);
    wr(3'd2, 1'b1, 16'h0F0F);
    wr(3'd7, 1'b1, 16'hC3C3);  // bit 2 ignored -> r3
    rd(3'd2, 1'b1, d); chk("R2 word r2", d, 16'h0F0F);
    rd(3'd3, 1'b1, d); chk("R2 word r3 via idx7 write", d, 16'hC3C3);
    rd(3'd5, 1'b1, d); chk("R2 word idx5 reads r1", d, 16'hAAAA);
    rd_b_idx = 3'd0; rd_b_size = 1'b1; rd_a_idx = 3'd0; rd_a_size = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 port A r0", rd_a_data, 16'h1234);
    chk("R7 port B r0", rd_b_data, 16'h1234);
  endtask

  task automatic t_alias;
    logic [15:0] d;
    rd(3'd0, 1'b0, d); chk("R3 low byte r0", d, 16'h0034);
    rd(3'd4, 1'b0, d); chk("R3 high byte r0", d, 16'h0012);
  endtask

  task automatic t_byte_write;
    logic [15:0] d;
    wr(3'd5, 1'b0, 16'hFFEE);  // r1 high <- EE
    rd(3'd1, 1'b1, d); chk("R4 high write keeps low", d, 16'hEEAA);
    wr(3'd1, 1'b0, 16'h0055);  // r1 low <- 55
    rd(3'd1, 1'b1, d); chk("R4 low write keeps high", d, 16'hEE55);
  endtask

  task automatic t_split;
    logic [15:0] d, e;
    wr(3'd6, 1'b0, 16'h0056);
    wr(3'd2, 1'b0, 16'h0078);
    wr(3'd3, 1'b1, 16'h5678);
    rd(3'd2, 1'b1, d);
    rd(3'd3, 1'b1, e);
    chk("R5 split bytes equal word write", d, e);
    chk("R5 split bytes value", d, 16'h5678);
  endtask

  task automatic t_same_cycle;
    logic [15:0] d;
    wr(3'd1, 1'b1, 16'hAAAA);
    wr_en = 1'b1; wr_idx = 3'd1; wr_size = 1'b1; wr_data = 16'hBBBB;
    rd_a_idx = 3'd1; rd_a_size = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk("R6 read during write gives old", rd_a_data, 16'hAAAA);
    rd(3'd1, 1'b1, d); chk("R6 next cycle gives new", d, 16'hBBBB);
  endtask

  task automatic t_move;
    logic [15:0] d;
    rd(3'd0, 1'b1, d);
    wr(3'd3, 1'b1, d);
    rd(3'd3, 1'b1, d); chk("R11 move dest", d, 16'h1234);
    rd(3'd0, 1'b1, d); chk("R11 move source unchanged", d, 16'h1234);
  endtask

  task automatic t_xchg_word;
    logic [15:0] d;
    wr(3'd1, 1'b1, 16'h1111);
    wr(3'd2, 1'b1, 16'h2222);
    xchg_start = 1'b1; xchg_idx_x = 3'd1; xchg_idx_y = 3'd2; xchg_size = 1'b1;
    @(posedge clk); @(negedge clk);
    xchg_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 busy in window", {15'b0, xchg_busy}, 16'h1);
      @(posedge clk); @(negedge clk);
    end
    chk("R8 busy clear after window", {15'b0, xchg_busy}, 16'h0);
    rd(3'd1, 1'b1, d); chk("R8 r1 after swap", d, 16'h2222);
    rd(3'd2, 1'b1, d); chk("R8 r2 after swap", d, 16'h1111);
  endtask

  task automatic run_swap(input logic [2:0] x, input logic [2:0] y, input logic sz);
    xchg_start = 1'b1; xchg_idx_x = x; xchg_idx_y = y; xchg_size = sz;
    @(posedge clk); @(negedge clk);
    xchg_start = 1'b0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_xchg_byte;
    logic [15:0] d;
    wr(3'd0, 1'b1, 16'hA1B2);
    run_swap(3'd0, 3'd4, 1'b0);  // halves of r0
    rd(3'd0, 1'b1, d); chk("R9 swap halves of one reg", d, 16'hB2A1);
    wr(3'd3, 1'b1, 16'h3344);
    wr(3'd1, 1'b1, 16'h5566);
    run_swap(3'd3, 3'd5, 1'b0);  // r3 low <-> r1 high
    rd(3'd3, 1'b1, d); chk("R9 r3 after byte swap", d, 16'h3355);
    rd(3'd1, 1'b1, d); chk("R9 r1 after byte swap", d, 16'h4466);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d;
    wr(3'd0, 1'b1, 16'h0A0A);
    wr(3'd2, 1'b1, 16'h0B0B);
    xchg_start = 1'b1; xchg_idx_x = 3'd0; xchg_idx_y = 3'd2; xchg_size = 1'b1;
    @(posedge clk); @(negedge clk);
    xchg_idx_x = 3'd1; xchg_idx_y = 3'd3;  // restart attempt
    wr_en = 1'b1; wr_idx = 3'd0; wr_size = 1'b1; wr_data = 16'hDEAD;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    xchg_start = 1'b0; wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 no restart, busy clear", {15'b0, xchg_busy}, 16'h0);
    rd(3'd0, 1'b1, d); chk("R10 write ignored r0", d, 16'h0B0B);
    rd(3'd2, 1'b1, d); chk("R10 r2 swapped", d, 16'h0A0A);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word();
    t_alias();
    t_byte_write();
    t_split();
    t_same_cycle();
    t_move();
    t_xchg_word();
    t_xchg_byte();
    t_busy_ignore();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule